// File: doc/BRIEF.md
# Synchronous Serial Bit-Clock Generator

This block produces the bit clock that travels next to the transmit data line when a UART is run in synchronous mode. The transmitter supplies it with frame and bit strobes: a frame-begin pulse, a bit-begin pulse carrying whether the bit is a data bit and whether it is the final data bit, a quarter-bit tick, and a frame-finish pulse. Data bits are sent least significant bit first, with 7, 8 or 9 per frame. From these strobes the block drives the clock pin level and its output enable. It produces exactly one clock period inside each data bit that is allowed to pulse. During start, parity and stop bits the pin stays at its rest level.

Four settings control the clock: synchronous mode on or off, rest level, capture phase, and whether the final data bit receives a pulse. The settings are copied into a holding register only on cycles where the transmitter enable is low. While the transmitter is enabled, the copy is frozen, so a setting changed in the middle of a transmission has no effect on the pin.

The sequencer has four states: `ST_IDLE`, `ST_START`, `ST_DATA` and `ST_TAIL`. Its transitions are:
- `T_GO` (`ST_IDLE` to `ST_START`) on frame-begin while enabled in synchronous mode.
- `T_FIRST` (`ST_START` to `ST_DATA`) on a data bit-begin.
- `T_NEXT` (`ST_DATA` to `ST_DATA`) on each further data bit-begin.
- `T_TAIL` (`ST_DATA` to `ST_TAIL`) on a non-data bit-begin.
- `T_DONE` (any busy state to `ST_IDLE`) on frame-finish.
- `T_ABORT` (any state to `ST_IDLE`) whenever the enable is low.

Top module: `sync_clk_gen`

## Requirements
- R1: After reset, `sclk_out` is 0 and `sclk_oe` is 0.
- R2: Outside a pulse the pin rests at the held rest level: low when `cfg_idle_high`=0, high when it is 1. A pulse drives the opposite level.
- R3: With `cfg_late_phase`=0 and 4 quarters per bit, the pin leaves the rest level on the edge that samples the first `qtr_tick` after a data `bit_start` (quarter 1). It returns to rest on the edge that samples the third tick (quarter 3).
- R4: With `cfg_late_phase`=1, the pin leaves the rest level at quarter 2 and returns on the edge that samples the next `bit_start`.
- R5: With `cfg_last_pulse`=1, a frame gives one pulse per data bit. With it at 0, the data bit begun with `bit_last`=1 stays at rest, giving one pulse fewer. This holds for 7, 8 and 9 data bits.
- R6: No pulse appears during the start bit, parity bit, stop bit or between frames.
- R7: When the held synchronous-mode setting is 0, `sclk_oe` is 0 and the pin never leaves the rest level.
- R8: Setting inputs changed while `tx_enable` is 1 have no effect on the pin until `tx_enable` has been low for a cycle.
- R9: Driving `tx_enable` low ends any frame. The pin is back at rest after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_enable | input | 1 | Transmitter enabled; settings are frozen while high |
| cfg_sync | input | 1 | Synchronous mode selection |
| cfg_idle_high | input | 1 | Rest level of the clock pin |
| cfg_late_phase | input | 1 | 0: capture on first edge, 1: capture on second edge |
| cfg_last_pulse | input | 1 | 1: final data bit gets a pulse |
| frame_start | input | 1 | Pulse at the beginning of a frame |
| frame_end | input | 1 | Pulse after the final stop bit |
| bit_start | input | 1 | Pulse at the beginning of each bit period |
| bit_data | input | 1 | Qualifies `bit_start`: this bit is a data bit |
| bit_last | input | 1 | Qualifies `bit_start`: this is the final data bit |
| qtr_tick | input | 1 | Pulse at each quarter boundary inside a bit |
| sclk_out | output | 1 | Clock pin level |
| sclk_oe | output | 1 | Clock pin output enable |

## Verification
All state is registered, and the pin is decoded combinationally from that state. The response to any strobe is therefore visible right after the clock edge that samples it, with zero further delay. Pulse onset is due 2 or 4 cycles after the bit-begin edge at two cycles per quarter, and the return is due 6 or 8 cycles after it. The bench drives each input after a falling edge and reads the pin at the next falling edge. It counts edges from the first data bit-begin, so each measured offset matches the quarter arithmetic of R3 and R4 exactly. Pulse totals, rest-level excursions and the abort response are read in that same sample, one edge after the stimulus that causes them.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_TAIL  = 2'd3
    } sclk_state_e;

    typedef struct packed {
        logic sync;
        logic idle_high;
        logic late_phase;
        logic last_pulse;
    } sclk_cfg_t;

endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold
    import sclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_enable,
    input  sclk_cfg_t cfg_in,
    output sclk_cfg_t cfg_q
);

    // settings are copied only while the transmitter is off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (!tx_enable) begin
            cfg_q <= cfg_in;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_enable |=> $stable(cfg_q)); // R8

endmodule

// File: rtl/sclk_bit_quarter.sv
module sclk_bit_quarter #(
    parameter int NUM_QTR = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_start,
    input  logic qtr_tick,
    input  logic late_phase,
    output logic win
);

    localparam int QW = (NUM_QTR > 1) ? $clog2(NUM_QTR) : 1;
    localparam logic [QW-1:0] Q_MAX   = QW'(NUM_QTR - 1);
    localparam logic [QW-1:0] EARLY_ON  = QW'(NUM_QTR / 4);
    localparam logic [QW-1:0] EARLY_OFF = QW'((3 * NUM_QTR) / 4);
    localparam logic [QW-1:0] LATE_ON   = QW'(NUM_QTR / 2);

    logic [QW-1:0] qcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qcnt <= '0;
        end else if (bit_start) begin
            qcnt <= '0;
        end else if (qtr_tick && (qcnt != Q_MAX)) begin
            qcnt <= qcnt + 1'b1;
        end
    end

    // pulse window inside a bit, chosen by capture phase
    always_comb begin
        if (late_phase) begin
            win = (qcnt >= LATE_ON);
        end else begin
            win = (qcnt >= EARLY_ON) && (qcnt < EARLY_OFF);
        end
    end

    AST_QTR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (qcnt == Q_MAX && qtr_tick && !bit_start) |=> (qcnt == Q_MAX)); // R3

    AST_QTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        bit_start |=> !win); // R4

endmodule

// File: rtl/sclk_frame_fsm.sv
module sclk_frame_fsm
    import sclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_enable,
    input  logic        sync_q,
    input  logic        frame_start,
    input  logic        frame_end,
    input  logic        bit_start,
    input  logic        bit_data,
    input  logic        bit_last,
    output sclk_state_e st,
    output logic        cur_last
);

    sclk_state_e st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cur_last <= 1'b0;
        end else begin
            st <= st_nx;
            if (bit_start) begin
                cur_last <= bit_data && bit_last;
            end
        end
    end

    always_comb begin
        st_nx = st;
        if (!tx_enable) begin
            st_nx = ST_IDLE;                              // T_ABORT
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (frame_start && sync_q) st_nx = ST_START; // T_GO
                end
                ST_START: begin
                    if (frame_end) st_nx = ST_IDLE;      // T_DONE
                    else if (bit_start && bit_data) st_nx = ST_DATA; // T_FIRST
                end
                ST_DATA: begin
                    if (frame_end) st_nx = ST_IDLE;      // T_DONE
                    else if (bit_start && !bit_data) st_nx = ST_TAIL; // T_TAIL
                    else st_nx = ST_DATA;                // T_NEXT
                end
                ST_TAIL: begin
                    if (frame_end) st_nx = ST_IDLE;      // T_DONE
                end
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> (st == ST_IDLE)); // R9

    AST_NO_DATA_WITHOUT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !sync_q) |=> (st == ST_IDLE)); // R7

endmodule

// File: rtl/sync_clk_gen.sv
module sync_clk_gen
    import sclk_pkg::*;
#(
    parameter int NUM_QTR = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_enable,
    input  logic cfg_sync,
    input  logic cfg_idle_high,
    input  logic cfg_late_phase,
    input  logic cfg_last_pulse,
    input  logic frame_start,
    input  logic frame_end,
    input  logic bit_start,
    input  logic bit_data,
    input  logic bit_last,
    input  logic qtr_tick,
    output logic sclk_out,
    output logic sclk_oe
);

    sclk_cfg_t   cfg_in;
    sclk_cfg_t   cfg_q;
    sclk_state_e st;
    logic        cur_last;
    logic        win;
    logic        emit;

    assign cfg_in = '{sync: cfg_sync, idle_high: cfg_idle_high,
                      late_phase: cfg_late_phase, last_pulse: cfg_last_pulse};

    sclk_cfg_hold u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_enable (tx_enable),
        .cfg_in    (cfg_in),
        .cfg_q     (cfg_q)
    );

    sclk_frame_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_enable   (tx_enable),
        .sync_q      (cfg_q.sync),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .bit_start   (bit_start),
        .bit_data    (bit_data),
        .bit_last    (bit_last),
        .st          (st),
        .cur_last    (cur_last)
    );

    sclk_bit_quarter #(.NUM_QTR(NUM_QTR)) u_qtr (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_start  (bit_start),
        .qtr_tick   (qtr_tick),
        .late_phase (cfg_q.late_phase),
        .win        (win)
    );

    // output decode
    always_comb begin
        emit     = cfg_q.sync && (st == ST_DATA) && (!cur_last || cfg_q.last_pulse);
        sclk_out = cfg_q.idle_high ^ (emit && win);
        sclk_oe  = cfg_q.sync;
    end

    AST_REST_OUTSIDE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_DATA) |-> (sclk_out == cfg_q.idle_high)); // R6

    AST_REST_WITHOUT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_oe |-> (sclk_out == cfg_q.idle_high)); // R7

    AST_LAST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && cur_last && !cfg_q.last_pulse) |-> (sclk_out == cfg_q.idle_high)); // R5

endmodule

// File: tb/tb_sync_clk_gen.sv
module tb_sync_clk_gen;

    logic clk = 1'b0;
    logic rst_n;
    logic tx_enable, cfg_sync, cfg_idle_high, cfg_late_phase, cfg_last_pulse;
    logic frame_start, frame_end, bit_start, bit_data, bit_last, qtr_tick;
    logic sclk_out, sclk_oe;

    always #10 clk = ~clk;

    sync_clk_gen dut (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .cfg_sync(cfg_sync),
        .cfg_idle_high(cfg_idle_high), .cfg_late_phase(cfg_late_phase),
        .cfg_last_pulse(cfg_last_pulse), .frame_start(frame_start),
        .frame_end(frame_end), .bit_start(bit_start), .bit_data(bit_data),
        .bit_last(bit_last), .qtr_tick(qtr_tick), .sclk_out(sclk_out), .sclk_oe(sclk_oe)
    );

    int n_chk = 0;
    int n_bad = 0;

    // {bits, rest, phase, last, 1'b0, pulses, on, off}
    localparam logic [23:0] VEC [8] = '{
        {4'd7, 1'b0, 1'b0, 1'b1, 1'b0, 4'd7, 4'd2, 8'd6},
        {4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7, 4'd2, 8'd6},
        {4'd9, 1'b1, 1'b0, 1'b1, 1'b0, 4'd9, 4'd2, 8'd6},
        {4'd8, 1'b1, 1'b1, 1'b1, 1'b0, 4'd8, 4'd4, 8'd8},
        {4'd7, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6, 4'd4, 8'd8},
        {4'd9, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8, 4'd4, 8'd8},
        {4'd8, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8, 4'd4, 8'd8},
        {4'd7, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6, 4'd2, 8'd6}
    };

    int   f_pulses, f_on, f_off, f_bad, f_j;
    logic f_idle, f_prev;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic fs, input logic fe, input logic bs,
                        input logic bd, input logic bl, input logic qt);
        frame_start = fs; frame_end = fe; bit_start = bs;
        bit_data = bd; bit_last = bl; qtr_tick = qt;
        @(posedge clk);
        @(negedge clk);
        frame_start = 0; frame_end = 0; bit_start = 0;
        bit_data = 0; bit_last = 0; qtr_tick = 0;
    endtask

    task automatic observe(input bit in_data);
        logic lvl;
        lvl = sclk_out;
        if (lvl != f_idle && f_prev == f_idle) f_pulses++;
        if (lvl != f_idle && !in_data) f_bad++;
        if (f_on < 0 && f_j >= 0 && lvl != f_idle) f_on = f_j;
        if (f_on >= 0 && f_off < 0 && lvl == f_idle) f_off = f_j;
        f_prev = lvl;
        if (f_j >= 0) f_j++;
    endtask

    // one bit period: 4 quarters of 2 cycles each
    task automatic bit_period(input logic bd, input logic bl, input bit first);
        step(0, 0, 1, bd, bl, 0);
        if (first) f_j = 0;
        observe(bd);
        for (int k = 1; k < 8; k++) begin
            step(0, 0, 0, 0, 0, (k % 2) == 0);
            observe(bd);
        end
    endtask

    task automatic run_frame(input int nbits, input logic rest);
        f_idle = rest; f_prev = rest;
        f_pulses = 0; f_on = -1; f_off = -1; f_bad = 0; f_j = -1;
        step(1, 0, 0, 0, 0, 0); observe(0);
        bit_period(0, 0, 0);
        for (int i = 0; i < nbits; i++) bit_period(1, i == nbits - 1, i == 0);
        bit_period(0, 0, 0);
        bit_period(0, 0, 0);
        step(0, 1, 0, 0, 0, 0); observe(0);
    endtask

    task automatic configure(input logic s, input logic p, input logic ph, input logic l);
        tx_enable = 0;
        cfg_sync = s; cfg_idle_high = p; cfg_late_phase = ph; cfg_last_pulse = l;
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        tx_enable = 1;
        step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n = 0; tx_enable = 0;
        cfg_sync = 0; cfg_idle_high = 0; cfg_late_phase = 0; cfg_last_pulse = 0;
        frame_start = 0; frame_end = 0; bit_start = 0; bit_data = 0; bit_last = 0; qtr_tick = 0;
        cfg_idle_high = 1; cfg_sync = 1;
        repeat (3) @(negedge clk);
        check("R1 reset sclk_out", sclk_out, 0);
        check("R1 reset sclk_oe", sclk_oe, 0);
        rst_n = 1;
        @(negedge clk);

        // table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < 8; v++) begin
            logic [23:0] e;
            e = VEC[v];
            configure(1, e[19], e[18], e[17]);
            check("R7 oe in sync mode", sclk_oe, 1);
            check("R2 rest level before frame", sclk_out, e[19]);
            run_frame(e[23:20], e[19]);
            check("R5 pulses per frame", f_pulses, e[15:12]);
            check(e[18] ? "R4 onset offset" : "R3 onset offset", f_on, e[11:8]);
            check(e[18] ? "R4 return offset" : "R3 return offset", f_off, e[7:0]);
            check("R6 excursions outside data bits", f_bad, 0);
        end

        // R7: asynchronous mode, pin stays at rest
        configure(0, 1, 0, 1);
        check("R7 oe off", sclk_oe, 0);
        run_frame(8, 1);
        check("R7 pulses without sync", f_pulses, 0);
        check("R7 level without sync", sclk_out, 1);

        // R8: settings changed while enabled are ignored
        configure(1, 0, 0, 1);
        cfg_idle_high = 1; cfg_last_pulse = 0; cfg_late_phase = 1; cfg_sync = 0;
        run_frame(8, 0);
        check("R8 pulses with frozen settings", f_pulses, 8);
        check("R8 onset with frozen phase", f_on, 2);
        check("R8 rest level frozen", sclk_out, 0);

        // R9: abort mid data bit
        configure(1, 0, 0, 1);
        step(1, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        for (int k = 1; k < 8; k++) step(0, 0, 0, 0, 0, (k % 2) == 0);
        step(0, 0, 1, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        check("R3 pulse active before abort", sclk_out, 1);
        tx_enable = 0;
        step(0, 0, 0, 0, 0, 0);
        check("R9 rest after abort", sclk_out, 0);

        summary();
    end

endmodule